// File: doc/BRIEF.md
# In-Order Superscalar Issue Gate

This block sits in the decode stage of a four-wide in-order pipeline. Each cycle the front end presents a group of up to four decoded instructions. Every slot carries a valid bit, a write-enable with a destination register, two optionally used source registers and a functional-unit class. The block decides which instructions at the head of the group may leave decode in this cycle, and it reports them as a contiguous issue mask and a count.

Two kinds of hazard are checked. The first kind is against work already in flight. A scoreboard keeps one pending-write bit per architectural register, and a busy input arrives for each functional-unit class. The second kind is between instructions of the same group. Each instruction is compared in program order against the instructions before it that have not yet left. The first instruction that cannot go blocks every instruction behind it.

A group stays at the input until all of its valid slots have issued. Slots that issued in earlier cycles are remembered, and checking resumes at the first slot that has not issued. When the last slot leaves, `grp_done` is raised and the front end presents the next group in the following cycle. Two writeback ports clear pending bits.

Top module: `issue_gate`

## Requirements
- R1: After reset no register is pending and no slot is marked issued, so a valid group of four independent instructions in four different classes issues completely: `issue_mask` = 4'b1111, `issue_cnt` = 4, `grp_done` = 1.
- R2: A slot stalls if an enabled source register other than register 0 has its pending bit set. A pending bit is set at the clock edge on which a writing instruction with a nonzero destination issues.
- R3: A slot stalls if an enabled source matches the nonzero destination of an earlier writing slot in the same group that has not issued in a previous cycle.
- R4: A writing slot stalls if its nonzero destination equals the destination of an earlier unissued writing slot in the group (WAW). It also stalls if that destination equals an enabled source of such an earlier slot (WAR).
- R5: Issue is in program order. Bit i of `issue_mask` stands for slot i. A slot issues only if every earlier unissued valid slot also issues in that cycle. `issue_cnt` equals the number of set mask bits.
- R6: A slot stalls if `fu_busy[c]` is 1 for its class c (class codes 0 to 3, bit c of `fu_busy`). It also stalls if an earlier unissued slot of the group uses the same class.
- R7: `grp_done` is 1 only while `grp_valid` is 1 and every valid slot has issued, either now or in an earlier cycle. Until then the same group is held and issued slots are never issued again. A group with no valid slots completes at once. Invalid slots neither issue nor block, and nothing issues while `grp_valid` is 0.
- R8: Each of the two writeback ports clears the pending bit of its register at the clock edge. When an issuing instruction sets the same register on that edge, the set wins.
- R9: Register 0 is never pending. Sources or destinations equal to 0 cause no hazard of any kind.
- R10: A writing slot stalls if its nonzero destination is already pending (WAW against an instruction in flight).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A group is presented |
| slot_v | input | 4 | Valid bit per slot |
| slot_wr | input | 4 | Slot writes its destination |
| slot_dst | input | 4x5 | Destination register per slot |
| slot_a_en | input | 4 | First source used |
| slot_a | input | 4x5 | First source register |
| slot_b_en | input | 4 | Second source used |
| slot_b | input | 4x5 | Second source register |
| slot_cls | input | 4x2 | Functional-unit class per slot |
| fu_busy | input | 4 | Busy flag per class |
| wb0_en | input | 1 | Writeback port 0 valid |
| wb0_reg | input | 5 | Register cleared by port 0 |
| wb1_en | input | 1 | Writeback port 1 valid |
| wb1_reg | input | 5 | Register cleared by port 1 |
| issue_mask | output | 4 | Slots leaving decode this cycle |
| issue_cnt | output | 3 | Number of slots leaving, 0 to 4 |
| grp_done | output | 1 | Group fully issued; next group may follow |

## Verification
The hardest case to reach is a group that is only partly issued: some slots have left, and a later slot is held by a pending bit that an earlier slot of the same group set. The stimulus reaches it with a chain in which slot 0 writes a register and slot 1 reads it. The group is held across cycles and checked again while the pending bit is still set. Then a writeback is fired, and the bench expects slot 1 and the independent slot behind it to issue together with `grp_done`. A set and a clear on the same register in the same edge is reached by firing a writeback at the register that is being issued.

// File: rtl/iss_pkg.sv
package iss_pkg;
    localparam int SLOTS = 4;
    localparam int NREG  = 32;
    localparam int RW    = $clog2(NREG);
    localparam int NCLS  = 4;
    localparam int CW    = $clog2(NCLS);
    localparam int CNTW  = $clog2(SLOTS + 1);
    localparam int NWB   = 2;

    typedef struct packed {
        logic          v;
        logic          wr;
        logic [RW-1:0] dst;
        logic          a_en;
        logic [RW-1:0] a;
        logic          b_en;
        logic [RW-1:0] b;
        logic [CW-1:0] cls;
    } slot_t;

    function automatic logic live_reg(input logic en, input logic [RW-1:0] r);
        return en && (r != '0);
    endfunction
endpackage

// File: rtl/iss_scoreboard.sv
module iss_scoreboard
    import iss_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SLOTS-1:0]          set_en,
    input  logic [SLOTS-1:0][RW-1:0]  set_reg,
    input  logic [NWB-1:0]            clr_en,
    input  logic [NWB-1:0][RW-1:0]    clr_reg,
    output logic [NREG-1:0]           pend
);
    logic [NREG-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int i = 0; i < SLOTS; i++)
            if (set_en[i]) set_vec[set_reg[i]] = 1'b1;
        for (int k = 0; k < NWB; k++)
            if (clr_en[k]) clr_vec[clr_reg[k]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= ((pend & ~clr_vec) | set_vec) & ~NREG'(1);
    end
endmodule

// File: rtl/iss_hazard.sv
module iss_hazard
    import iss_pkg::*;
#(
    parameter int IDX = 0
) (
    input  slot_t [SLOTS-1:0] grp,
    input  logic  [SLOTS-1:0] rem,
    input  logic  [NREG-1:0]  pend,
    input  logic  [NCLS-1:0]  fu_busy,
    output logic              free
);
    slot_t cur;
    logic  cur_w;
    assign cur   = grp[IDX];
    assign cur_w = live_reg(cur.wr, cur.dst);

    always_comb begin
        free = 1'b1;
        // in-flight RAW, WAW and structural checks
        if (live_reg(cur.a_en, cur.a) && pend[cur.a]) free = 1'b0;
        if (live_reg(cur.b_en, cur.b) && pend[cur.b]) free = 1'b0;
        if (cur_w && pend[cur.dst])                   free = 1'b0;
        if (fu_busy[cur.cls])                         free = 1'b0;
        // in-group checks against earlier unissued slots
        for (int j = 0; j < IDX; j++) begin
            if (rem[j]) begin
                if (live_reg(grp[j].wr, grp[j].dst)) begin
                    if (live_reg(cur.a_en, cur.a) && cur.a == grp[j].dst) free = 1'b0;
                    if (live_reg(cur.b_en, cur.b) && cur.b == grp[j].dst) free = 1'b0;
                    if (cur_w && cur.dst == grp[j].dst)                 free = 1'b0;
                end
                if (cur_w && grp[j].a_en && grp[j].a == cur.dst) free = 1'b0;
                if (cur_w && grp[j].b_en && grp[j].b == cur.dst) free = 1'b0;
                if (grp[j].cls == cur.cls)                       free = 1'b0;
            end
        end
    end
endmodule

// File: rtl/iss_select.sv
module iss_select
    import iss_pkg::*;
(
    input  logic              grp_valid,
    input  logic [SLOTS-1:0]  rem,
    input  logic [SLOTS-1:0]  free,
    output logic [SLOTS-1:0]  mask,
    output logic [CNTW-1:0]   cnt,
    output logic              done
);
    logic run;

    always_comb begin
        run  = 1'b1;
        mask = '0;
        cnt  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rem[i]) begin
                if (run && free[i]) mask[i] = 1'b1;
                else                run     = 1'b0;
            end
            cnt = cnt + CNTW'(mask[i]);
        end
        done = grp_valid && ((rem & ~mask) == '0);
    end
endmodule

// File: rtl/issue_gate.sv
module issue_gate
    import iss_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     grp_valid,
    input  logic [SLOTS-1:0]         slot_v,
    input  logic [SLOTS-1:0]         slot_wr,
    input  logic [SLOTS-1:0][RW-1:0] slot_dst,
    input  logic [SLOTS-1:0]         slot_a_en,
    input  logic [SLOTS-1:0][RW-1:0] slot_a,
    input  logic [SLOTS-1:0]         slot_b_en,
    input  logic [SLOTS-1:0][RW-1:0] slot_b,
    input  logic [SLOTS-1:0][CW-1:0] slot_cls,
    input  logic [NCLS-1:0]          fu_busy,
    input  logic                     wb0_en,
    input  logic [RW-1:0]            wb0_reg,
    input  logic                     wb1_en,
    input  logic [RW-1:0]            wb1_reg,
    output logic [SLOTS-1:0]         issue_mask,
    output logic [CNTW-1:0]          issue_cnt,
    output logic                     grp_done
);
    slot_t [SLOTS-1:0] grp;
    logic  [SLOTS-1:0] done_q, rem, free, set_en;
    logic  [NREG-1:0]  pend;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign grp[i] = '{v: slot_v[i], wr: slot_wr[i], dst: slot_dst[i],
                          a_en: slot_a_en[i], a: slot_a[i],
                          b_en: slot_b_en[i], b: slot_b[i], cls: slot_cls[i]};
        assign set_en[i] = issue_mask[i] && live_reg(slot_wr[i], slot_dst[i]);

        iss_hazard #(.IDX(i)) u_hz (
            .grp(grp), .rem(rem), .pend(pend), .fu_busy(fu_busy), .free(free[i])
        );
    end

    assign rem = grp_valid ? (slot_v & ~done_q) : '0;

    iss_select u_sel (
        .grp_valid(grp_valid), .rem(rem), .free(free),
        .mask(issue_mask), .cnt(issue_cnt), .done(grp_done)
    );

    iss_scoreboard u_sb (
        .clk(clk), .rst(rst),
        .set_en(set_en), .set_reg(slot_dst),
        .clr_en({wb1_en, wb0_en}), .clr_reg({wb1_reg, wb0_reg}),
        .pend(pend)
    );

    always_ff @(posedge clk) begin
        if (rst)            done_q <= '0;
        else if (grp_done)  done_q <= '0;
        else if (grp_valid) done_q <= done_q | issue_mask;
    end
endmodule

// File: rtl/issue_gate_chk.sv
module issue_gate_chk
    import iss_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     grp_valid,
    input logic [SLOTS-1:0]         issue_mask,
    input logic                     grp_done,
    input logic [SLOTS-1:0]         slot_wr,
    input logic [SLOTS-1:0][RW-1:0] slot_dst,
    input logic [SLOTS-1:0]         slot_a_en,
    input logic [SLOTS-1:0][RW-1:0] slot_a,
    input logic [SLOTS-1:0][CW-1:0] slot_cls,
    input logic [NCLS-1:0]          fu_busy,
    input logic [NREG-1:0]          pend
);
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !grp_valid |-> issue_mask == '0);

    p_no_reissue_r7: assert property (@(posedge clk) disable iff (rst)
        (grp_valid && !grp_done && issue_mask != '0) |=> ((issue_mask & $past(issue_mask)) == '0));

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_mask[0] && slot_wr[0] && slot_dst[0] != '0) |=> pend[$past(slot_dst[0])]);

    p_src_free_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_mask[0] && slot_a_en[0] && slot_a[0] != '0) |-> !pend[slot_a[0]]);

    p_unit_free_r6: assert property (@(posedge clk) disable iff (rst)
        issue_mask[0] |-> !fu_busy[slot_cls[0]]);

    p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
        issue_mask[0] |=> !pend[0]);
endmodule

bind issue_gate issue_gate_chk u_chk (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .issue_mask(issue_mask),
    .grp_done(grp_done), .slot_wr(slot_wr), .slot_dst(slot_dst),
    .slot_a_en(slot_a_en), .slot_a(slot_a), .slot_cls(slot_cls),
    .fu_busy(fu_busy), .pend(pend)
);

// File: tb/issue_gate_bench.sv
module issue_gate_bench;
    import iss_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic grp_valid;
    logic [SLOTS-1:0] slot_v, slot_wr, slot_a_en, slot_b_en;
    logic [SLOTS-1:0][RW-1:0] slot_dst, slot_a, slot_b;
    logic [SLOTS-1:0][CW-1:0] slot_cls;
    logic [NCLS-1:0] fu_busy;
    logic wb0_en, wb1_en;
    logic [RW-1:0] wb0_reg, wb1_reg;
    logic [SLOTS-1:0] issue_mask;
    logic [CNTW-1:0] issue_cnt;
    logic grp_done;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    issue_gate u_issue_gate (.*);

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic chk_out(input string req, input int m, input int d);
        int c = 0;
        for (int i = 0; i < SLOTS; i++) c += (m >> i) & 1;
        chk({req, " mask"}, int'(issue_mask), m);
        chk({req, " cnt"}, int'(issue_cnt), c);
        chk({req, " done"}, int'(grp_done), d);
    endtask

    task automatic clear_slots();
        slot_v = '0; slot_wr = '0; slot_a_en = '0; slot_b_en = '0;
        slot_dst = '0; slot_a = '0; slot_b = '0; slot_cls = '0;
    endtask

    task automatic put(input int i, input bit wr, input int dst, input bit ae,
                       input int a, input bit be, input int b, input int cls);
        slot_v[i] = 1'b1; slot_wr[i] = wr; slot_dst[i] = RW'(dst);
        slot_a_en[i] = ae; slot_a[i] = RW'(a);
        slot_b_en[i] = be; slot_b[i] = RW'(b); slot_cls[i] = CW'(cls);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; grp_valid = 1'b0; fu_busy = '0; clear_slots();
        wb0_en = 1'b0; wb1_en = 1'b0; wb0_reg = '0; wb1_reg = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_full();  // R1
        do_reset();
        #1 chk_out("R1 idle", 0, 0);
        @(negedge clk);
        grp_valid = 1'b1;
        put(0, 1, 1, 1, 10, 1, 11, 0);
        put(1, 1, 2, 1, 12, 0, 0, 1);
        put(2, 1, 3, 1, 13, 1, 14, 2);
        put(3, 1, 4, 0, 0, 1, 15, 3);
        #1 chk_out("R1 full group", 4'b1111, 1);
    endtask

    task automatic t_raw_pending();  // R2, R8
        do_reset();
        grp_valid = 1'b1; clear_slots(); put(0, 1, 5, 0, 0, 0, 0, 0);
        #1 chk_out("R2 producer", 4'b0001, 1);
        @(negedge clk);
        clear_slots(); put(0, 0, 0, 0, 0, 1, 5, 1);
        wb1_en = 1'b1; wb1_reg = 5'd5;
        #1 chk_out("R2 source pending", 0, 0);
        @(negedge clk);
        wb1_en = 1'b0;
        #1 chk_out("R8 cleared by port 1", 4'b0001, 1);
    endtask

    task automatic t_group_chain();  // R3, R5, R7, R8
        do_reset();
        grp_valid = 1'b1; clear_slots();
        put(0, 1, 6, 0, 0, 0, 0, 0);
        put(1, 1, 7, 1, 6, 0, 0, 1);
        put(2, 1, 8, 1, 20, 0, 0, 2);
        #1 chk_out("R3 in-group RAW", 4'b0001, 0);
        @(negedge clk);
        #1 chk_out("R7 held, slot1 waits on pending", 0, 0);
        @(negedge clk);
        wb0_en = 1'b1; wb0_reg = 5'd6;
        #1 chk_out("R7 still held", 0, 0);
        @(negedge clk);
        wb0_en = 1'b0;
        #1 chk_out("R7 rest of group drains", 4'b0110, 1);
        @(negedge clk);
        grp_valid = 1'b0;
        #1 chk_out("R7 no group", 0, 0);
    endtask

    task automatic t_waw_war();  // R4
        do_reset();
        grp_valid = 1'b1; clear_slots();
        put(0, 1, 7, 1, 8, 0, 0, 0);
        put(1, 1, 8, 0, 0, 0, 0, 1);
        #1 chk_out("R4 WAR in group", 4'b0001, 0);
        do_reset();
        grp_valid = 1'b1; clear_slots();
        put(0, 1, 9, 0, 0, 0, 0, 0);
        put(1, 1, 9, 0, 0, 0, 0, 1);
        #1 chk_out("R4 WAW in group", 4'b0001, 0);
    endtask

    task automatic t_struct();  // R6, R5
        do_reset();
        fu_busy = 4'b0100; grp_valid = 1'b1; clear_slots();
        put(0, 0, 0, 0, 0, 0, 0, 2);
        #1 chk_out("R6 class busy", 0, 0);
        do_reset();
        grp_valid = 1'b1; clear_slots();
        put(0, 1, 1, 0, 0, 0, 0, 1);
        put(1, 1, 2, 0, 0, 0, 0, 1);
        #1 chk_out("R6 same class in group", 4'b0001, 0);
        do_reset();
        fu_busy = 4'b0100; grp_valid = 1'b1; clear_slots();
        put(0, 1, 1, 0, 0, 0, 0, 0);
        put(1, 1, 2, 0, 0, 0, 0, 2);
        put(2, 1, 3, 0, 0, 0, 0, 3);
        #1 chk_out("R5 later free slot blocked", 4'b0001, 0);
    endtask

    task automatic t_reg_zero();  // R9
        do_reset();
        grp_valid = 1'b1; clear_slots();
        put(0, 1, 0, 0, 0, 0, 0, 0);
        put(1, 1, 0, 1, 0, 1, 0, 1);
        #1 chk_out("R9 r0 ignored in group", 4'b0011, 1);
        @(negedge clk);
        clear_slots(); put(0, 1, 0, 1, 0, 0, 0, 2);
        #1 chk_out("R9 r0 never pending", 4'b0001, 1);
    endtask

    task automatic t_set_wins();  // R8
        do_reset();
        grp_valid = 1'b1; clear_slots(); put(0, 1, 12, 0, 0, 0, 0, 0);
        wb0_en = 1'b1; wb0_reg = 5'd12;
        #1 chk_out("R8 set issue", 4'b0001, 1);
        @(negedge clk);
        wb0_en = 1'b0;
        clear_slots(); put(0, 0, 0, 1, 12, 0, 0, 1);
        #1 chk_out("R8 set beats clear", 0, 0);
    endtask

    task automatic t_waw_flight();  // R10
        do_reset();
        grp_valid = 1'b1; clear_slots(); put(0, 1, 13, 0, 0, 0, 0, 0);
        #1 chk_out("R10 first writer", 4'b0001, 1);
        @(negedge clk);
        clear_slots(); put(0, 1, 13, 0, 0, 0, 0, 1);
        #1 chk_out("R10 WAW in flight", 0, 0);
    endtask

    task automatic t_empty_hole();  // R7
        do_reset();
        grp_valid = 1'b1; clear_slots();
        #1 chk_out("R7 empty group", 0, 1);
        @(negedge clk);
        put(0, 1, 3, 0, 0, 0, 0, 0);
        put(2, 1, 4, 0, 0, 0, 0, 1);
        #1 chk_out("R7 hole slot", 4'b0101, 1);
    endtask

    initial begin
        fork
            begin
                t_reset_full();
                t_raw_pending();
                t_group_chain();
                t_waw_war();
                t_struct();
                t_reg_zero();
                t_set_wins();
                t_waw_flight();
                t_empty_hole();
            end
            begin
                repeat (200000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired got=1 expected=0");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule